// File: doc/BRIEF.md
# Dual-Rate Sample Strobe Generator

This block produces the sample-enable strobe for an acquisition path. It runs from a 100 MHz master clock and divides it by a programmable count. The count comes from an interval code made of a mantissa (1, 2 or 4) and a power-of-ten exponent. The smallest interval is one master cycle (10 ns) and the largest is 10^MAX_EXP cycles. With the default of 7 that is 100 ms.

Two codes are held: one for the pretrigger part of a record and one for the post-trigger part. The first trigger after reset switches the divider to the post-trigger code. On that switch the divider restarts from zero, so the first post-trigger strobe comes one full new interval after the trigger. A gate input pauses strobe generation.

Instead of the divider, an external sample clock can be selected. It is brought into the master-clock domain through a synchroniser, and each of its rising edges gives one strobe.

Top module: `sample_clk_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `sample_en` is low, the pretrigger code is in force and the divider count is zero. In internal mode with the gate high, the first strobe is seen on the D-th cycle after reset is released, where D is the divide count of the pretrigger code.
- R2: An interval code is `{exponent, mantissa}`, with the mantissa in the two low bits. Mantissa field 0 means 1, field 1 means 2 and field 2 means 4. In internal mode with the gate high, strobes recur every mantissa × 10^exponent master cycles.
- R3: Out-of-range codes are clamped. Mantissa field 3 is treated as 4. Any exponent above MAX_EXP, and exponent MAX_EXP with a mantissa above 1, give 10^MAX_EXP cycles.
- R4: Before the first trigger, the interval is set by `pre_code` alone.
- R5: A trigger pulse sampled on clock edge k moves the block to the post-trigger code. It clears the divider and suppresses any strobe from edge k. The next strobe goes high at edge k+Dpost, and after that strobes recur every Dpost cycles.
- R6: Once the post-trigger code is in force, further trigger pulses have no effect until reset.
- R7: While `gate` is low, no strobe is produced and the divider holds its count. Each cycle with the gate low stretches the current interval by one cycle.
- R8: With `ext_sel` high, the divider is held at zero. Each rising edge of `ext_clk` gives exactly one one-cycle strobe. When `ext_clk` rises before edge e, the strobe is high after edge e+2. This holds for external clocks at up to half the master rate.
- R9: In external mode, rising edges of `ext_clk` seen while `gate` is low give no strobe.
- R10: A divide count of 1 keeps `sample_en` high on every cycle. Any larger count gives strobes exactly one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_code | input | CODE_W | Interval code used before the trigger |
| post_code | input | CODE_W | Interval code used after the trigger |
| trig | input | 1 | Trigger event, one master-clock cycle wide |
| ext_sel | input | 1 | Selects the external sample clock |
| ext_clk | input | 1 | External sample clock, asynchronous |
| gate | input | 1 | Enables strobe generation when high |
| sample_en | output | 1 | Sample-enable strobe |

## Verification
The assertions check these properties on every cycle:
- a low gate blocks the next strobe;
- the post-trigger phase never reverts;
- the cycle after the switching trigger carries no strobe;
- the external mode keeps the divider cleared and never gives back-to-back strobes;
- the divider count stays within the largest legal interval.

Only the bench scenarios can show the timing itself. That covers the exact interval for every code in a small configuration, including the clamped codes. It also covers the placement of the first post-trigger strobe, the stretch caused by a gate pause, and the three-cycle latency of the external path.

// File: rtl/scg_pkg.sv
package scg_pkg;

    typedef enum logic {
        PH_PRE  = 1'b0,
        PH_POST = 1'b1
    } phase_e;

    // Ten raised to e, computed by repeated multiplication.
    function automatic int unsigned pow10(input int unsigned e);
        int unsigned r;
        r = 1;
        for (int unsigned i = 0; i < e; i++) begin
            r = r * 10;
        end
        return r;
    endfunction

endpackage

// File: rtl/scg_code_decode.sv
module scg_code_decode
    import scg_pkg::*;
#(
    parameter int MAX_EXP = 7,
    parameter int EXP_W   = 3,
    parameter int CNT_W   = 24
) (
    input  logic [EXP_W+1:0] code,
    output logic [CNT_W-1:0] div_count
);
    localparam int          NUM_EXP = 1 << EXP_W;
    localparam int unsigned TOP_V   = pow10(MAX_EXP);

    logic [CNT_W-1:0] tab [NUM_EXP*4];

    // One entry per code; clamping is folded into the constant.
    for (genvar g = 0; g < NUM_EXP; g++) begin : g_exp
        for (genvar h = 0; h < 4; h++) begin : g_mant
            localparam int unsigned MV  = (h == 0) ? 1 : ((h == 1) ? 2 : 4);
            localparam int unsigned RAW = (g > MAX_EXP) ? TOP_V :
                                          ((g == MAX_EXP) && (MV > 1)) ? TOP_V :
                                          MV * pow10(g);
            assign tab[g*4 + h] = CNT_W'(RAW);
        end
    end

    assign div_count = tab[code];

endmodule

// File: rtl/scg_divider.sv
module scg_divider #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             hold,
    input  logic [CNT_W-1:0] limit,
    output logic             tick,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    // Comparing with >= recovers the counter if the limit drops below it.
    assign tick  = !clear && !hold && (st_q.cnt >= (limit - CNT_W'(1)));
    assign count = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.cnt = '0;
        end else if (hold) begin
            st_d.cnt = st_q.cnt;
        end else if (tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/scg_edge_sync.sv
module scg_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } sync_state_t;

    sync_state_t st_d, st_q;

    assign rise = st_q.sync[STAGES-1] & ~st_q.prev;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], async_in};
        st_d.prev = st_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sample_clk_gen.sv
module sample_clk_gen
    import scg_pkg::*;
#(
    parameter  int MAX_EXP     = 7,
    parameter  int SYNC_STAGES = 2,
    localparam int EXP_W       = (MAX_EXP < 1) ? 1 : $clog2(MAX_EXP + 1),
    localparam int CODE_W      = EXP_W + 2,
    localparam int CNT_W       = $clog2((10 ** MAX_EXP) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] pre_code,
    input  logic [CODE_W-1:0] post_code,
    input  logic              trig,
    input  logic              ext_sel,
    input  logic              ext_clk,
    input  logic              gate,
    output logic              sample_en
);
    typedef struct packed {
        phase_e phase;
        logic   strobe;
    } top_state_t;

    top_state_t       st_d, st_q;
    logic [CNT_W-1:0] div_pre, div_post, div_limit, div_cnt;
    logic             div_tick, ext_rise, restart;

    scg_code_decode #(.MAX_EXP(MAX_EXP), .EXP_W(EXP_W), .CNT_W(CNT_W)) u_dec_pre (
        .code      (pre_code),
        .div_count (div_pre)
    );

    scg_code_decode #(.MAX_EXP(MAX_EXP), .EXP_W(EXP_W), .CNT_W(CNT_W)) u_dec_post (
        .code      (post_code),
        .div_count (div_post)
    );

    assign restart   = trig && (st_q.phase == PH_PRE);
    assign div_limit = (st_q.phase == PH_POST) ? div_post : div_pre;

    scg_divider #(.CNT_W(CNT_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (restart || ext_sel),
        .hold  (!gate),
        .limit (div_limit),
        .tick  (div_tick),
        .count (div_cnt)
    );

    scg_edge_sync #(.STAGES(SYNC_STAGES)) u_ext (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_clk),
        .rise     (ext_rise)
    );

    always_comb begin
        st_d        = st_q;
        st_d.phase  = trig ? PH_POST : st_q.phase;
        st_d.strobe = ext_sel ? (ext_rise && gate) : div_tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_PRE, strobe: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sample_en = st_q.strobe;

endmodule

// File: rtl/scg_checker.sv
module scg_checker
    import scg_pkg::*;
#(
    parameter int MAX_EXP = 7,
    parameter int CNT_W   = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gate,
    input logic             ext_sel,
    input logic             trig,
    input logic             strobe,
    input phase_e           phase,
    input logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(pow10(MAX_EXP) - 1);

    a_r7_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |=> !strobe);

    a_r6_phase_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_POST) |=> (phase == PH_POST));

    a_r5_switch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PRE && trig && !ext_sel) |=> (!strobe && phase == PH_POST));

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_MAX);

    a_r8_ext_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ext_sel |=> (cnt == '0));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_sel && $past(ext_sel) && strobe) |=> !strobe);

endmodule

bind sample_clk_gen scg_checker #(.MAX_EXP(MAX_EXP), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .gate    (gate),
    .ext_sel (ext_sel),
    .trig    (trig),
    .strobe  (sample_en),
    .phase   (st_q.phase),
    .cnt     (div_cnt)
);

// File: tb/sample_clk_gen_bench.sv
module sample_clk_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAXE       = 2;
    localparam int CW         = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] pre_code = '0;
    logic [CW-1:0] post_code = '0;
    logic          trig = 1'b0;
    logic          ext_sel = 1'b0;
    logic          ext_clk = 1'b0;
    logic          gate = 1'b1;
    logic          sample_en;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sample_clk_gen #(.MAX_EXP(MAXE)) u_sample_clk_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .pre_code  (pre_code),
        .post_code (post_code),
        .trig      (trig),
        .ext_sel   (ext_sel),
        .ext_clk   (ext_clk),
        .gate      (gate),
        .sample_en (sample_en)
    );

    function automatic int exp_div(input int code);
        int e, m, mv, p;
        e  = code >> 2;
        m  = code & 3;
        mv = (m == 0) ? 1 : ((m == 1) ? 2 : 4);
        p  = 1;
        for (int i = 0; i < e; i++) p = p * 10;
        if (e > MAXE) return 100;
        if (e == MAXE && mv > 1) return 100;
        return mv * p;
    endfunction

    function automatic bit is_clamped(input int code);
        return ((code & 3) == 3) || ((code >> 2) > MAXE) ||
               (((code >> 2) == MAXE) && ((code & 3) != 0));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic wait_strobe(input int lim, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sample_en && n < lim);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(sample_en == 1'b0, "R1 strobe low in reset", int'(sample_en), 0);
        rst_n = 1'b1;
    endtask

    task automatic count_strobes(input int cycles, output int s);
        s = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (sample_en) s++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int n, d, s;

        // R1 R2 R3 R10: every code, pretrigger phase
        for (int c = 0; c < 16; c++) begin
            pre_code = CW'(c); post_code = CW'(c);
            ext_sel = 1'b0; gate = 1'b1;
            d = exp_div(c);
            do_reset();
            wait_strobe(300, n);
            check(n == d, "R1 first strobe after reset", n, d);
            if (d == 1) begin
                for (int k = 0; k < 3; k++) begin
                    @(negedge clk);
                    check(sample_en == 1'b1, "R10 divide by one", int'(sample_en), 1);
                end
            end else begin
                wait_strobe(300, n);
                check(n == d, is_clamped(c) ? "R3 clamped interval" : "R2 interval", n, d);
            end
        end

        // R4 R5 R6: rate switch at the trigger
        pre_code = 4'b0001;   // 2 cycles
        post_code = 4'b0100;  // 10 cycles
        do_reset();
        wait_strobe(300, n);
        wait_strobe(300, n);
        check(n == 2, "R4 pretrigger interval", n, 2);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        check(sample_en == 1'b0, "R5 no strobe at switch", int'(sample_en), 0);
        wait_strobe(300, n);
        check(n == 10, "R5 first post-trigger strobe", n, 10);
        wait_strobe(300, n);
        check(n == 10, "R5 post-trigger interval", n, 10);
        repeat (3) @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        wait_strobe(300, n);
        check(n == 6, "R6 retrigger ignored", n, 6);
        wait_strobe(300, n);
        check(n == 10, "R6 interval kept", n, 10);

        // R7: gate pause
        pre_code = 4'b0100; post_code = 4'b0100;
        do_reset();
        wait_strobe(300, n);
        gate = 1'b0;
        s = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (sample_en) s++;
        end
        check(s == 0, "R7 no strobe while gated", s, 0);
        gate = 1'b1;
        wait_strobe(300, n);
        check(n == 10, "R7 count held across gate", n, 10);
        gate = 1'b0;
        count_strobes(40, s);
        check(s == 0, "R7 long gate", s, 0);
        gate = 1'b1;

        // R8 R9 R10: external clock
        ext_sel = 1'b1; pre_code = 4'b0000;
        do_reset();
        repeat (4) @(negedge clk);
        for (int p = 0; p < 4; p++) begin
            ext_clk = 1'b1;
            wait_strobe(20, n);
            check(n == 3, "R8 external latency", n, 3);
            count_strobes(4, s);
            check(s == 0, "R10 one-cycle external strobe", s, 0);
            ext_clk = 1'b0;
            repeat (3) @(negedge clk);
        end
        s = 0;
        for (int p = 0; p < 10; p++) begin
            @(negedge clk); ext_clk = 1'b1; if (sample_en) s++;
            @(negedge clk); ext_clk = 1'b0; if (sample_en) s++;
        end
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (sample_en) s++;
        end
        check(s == 10, "R8 half-rate external clock", s, 10);
        gate = 1'b0;
        s = 0;
        for (int p = 0; p < 5; p++) begin
            @(negedge clk); ext_clk = 1'b1; if (sample_en) s++;
            @(negedge clk); if (sample_en) s++;
            @(negedge clk); ext_clk = 1'b0; if (sample_en) s++;
            @(negedge clk); if (sample_en) s++;
        end
        check(s == 0, "R9 gated external edges", s, 0);
        gate = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule